// File: doc/BRIEF.md
# Sixteen-Entry Two-Bit-Per-Channel Colour Lookup

This block turns a 4-bit pixel index into an 8-bit-per-channel RGB triple through a 16-entry table. Each entry holds one data byte; its low six bits pack three 2-bit channel codes. Each code widens to 8 bits by scaling with 85, which gives the four levels 0, 85, 170 and 255.

The table is loaded over a byte-wide port. A control byte write latches the table index from its bits 5:2. A later palette write stores the data byte at that latched index. The byte at the latched index is always visible on the readback output.

The pixel side samples the index and an active-area flag on each clock. The colour appears on the RGB outputs one clock later. A pixel outside the active area shows black. An entry that has not been written since reset shows a built-in grey ramp: entry 0 is full white and entry i is grey level i.

Top module: `pal16_lut`

## Requirements
- R1: After reset, the latched index is 0, the RGB outputs are 0, and every entry reads back as 0x00.
- R2: A pulse on `ctl_wr` latches `ctl_byte[5:2]` as the table index. Bits 7:6 and 1:0 of the control byte have no effect. Without `ctl_wr` the index holds its value.
- R3: A pulse on `pal_wr` stores all 8 bits of `pal_wdata` at the index latched before that clock edge. This holds even when `ctl_wr` pulses in the same cycle. `pal_rdata` shows the byte stored at the current index without delay.
- R4: Red is taken from entry bits 1:0, green from bits 3:2 and blue from bits 5:4. Entry bits 7:6 have no effect on colour.
- R5: A 2-bit channel code v is output as 85·v, so the codes 0, 1, 2 and 3 give 0, 85, 170 and 255.
- R6: Until an entry is first written, it shows as 255 on every channel for entry 0 and as the value i on every channel for entry i (1 to 15). Once written, it shows the stored colour.
- R7: The RGB outputs are registered. The colour for the `pix_idx` and `pix_active` sampled at a clock edge appears after that edge. When `pix_active` is 0, the outputs after the edge are 0.
- R8: The pixel lookup at a clock edge uses the table contents from before that edge. A write at edge k affects the colour first at edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel and bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control byte write strobe |
| ctl_byte | input | 8 | Control byte; bits 5:2 select the table index |
| pal_wr | input | 1 | Palette byte write strobe |
| pal_wdata | input | 8 | Byte to store at the latched index |
| pal_rdata | output | 8 | Byte stored at the latched index |
| pix_idx | input | 4 | Pixel colour index |
| pix_active | input | 1 | Pixel lies in the active area |
| red | output | 8 | Red level, registered |
| green | output | 8 | Green level, registered |
| blue | output | 8 | Blue level, registered |

## Verification
The hardest cases to reach are where several clock-edge events coincide. One is a control write and a palette write in the same cycle, which must store at the old index. Another is a pixel lookup of an entry in the very cycle it is being written, which must still show the old colour or the grey ramp.

The stimulus creates these collisions on purpose. It then runs a long random phase in which strobes, indices and data overlap freely. A behavioural model tracks which entries have been written and predicts every output on every clock.

// File: rtl/pal16_pkg.sv
package pal16_pkg;
  localparam int PAL_IDX_W  = 4;
  localparam int PAL_DATA_W = 8;
  localparam int PAL_CH_W   = 2;
  localparam int PAL_OUT_W  = 8;
  localparam int PAL_IDX_LSB = 2;

  // Scale a 2-bit code to the 8-bit range: full scale / max code = 85.
  function automatic logic [PAL_OUT_W-1:0] widen_code(input logic [PAL_CH_W-1:0] code);
    logic [PAL_OUT_W-1:0] step;
    step = PAL_OUT_W'(((1 << PAL_OUT_W) - 1) / ((1 << PAL_CH_W) - 1));
    return PAL_OUT_W'(code) * step;
  endfunction

  // Built-in ramp shown by entries not yet written.
  function automatic logic [PAL_OUT_W-1:0] ramp_level(input logic [PAL_IDX_W-1:0] idx);
    return (idx == '0) ? {PAL_OUT_W{1'b1}} : PAL_OUT_W'(idx);
  endfunction
endpackage

// File: rtl/pal16_index_latch.sv
module pal16_index_latch #(
  parameter int DATA_W  = pal16_pkg::PAL_DATA_W,
  parameter int IDX_W   = pal16_pkg::PAL_IDX_W,
  parameter int IDX_LSB = pal16_pkg::PAL_IDX_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [DATA_W-1:0] ctl_byte,
  output logic [IDX_W-1:0]  idx_q
);
  localparam int IDX_MSB = IDX_LSB + IDX_W - 1;

  always_ff @(posedge clk) begin
    if (!rst_n)      idx_q <= '0;
    else if (ctl_wr) idx_q <= ctl_byte[IDX_MSB:IDX_LSB];
  end

  assert_idx_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> idx_q == $past(ctl_byte[IDX_MSB:IDX_LSB]));
  assert_idx_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_wr |=> $stable(idx_q));
endmodule

// File: rtl/pal16_store.sv
module pal16_store #(
  parameter int IDX_W  = pal16_pkg::PAL_IDX_W,
  parameter int DATA_W = pal16_pkg::PAL_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic [IDX_W-1:0]  lk_idx,
  output logic [DATA_W-1:0] lk_data,
  output logic              lk_written
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] entry   [DEPTH];
  logic [DEPTH-1:0]  written;

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    wire hit = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        entry[g]   <= '0;
        written[g] <= 1'b0;
      end else if (hit) begin
        entry[g]   <= wr_data;
        written[g] <= 1'b1;
      end
    end
  end

  assign rd_data    = entry[wr_idx];
  assign lk_data    = entry[lk_idx];
  assign lk_written = written[lk_idx];
endmodule

// File: rtl/pal16_lookup.sv
module pal16_lookup #(
  parameter int IDX_W  = pal16_pkg::PAL_IDX_W,
  parameter int DATA_W = pal16_pkg::PAL_DATA_W,
  parameter int CH_W   = pal16_pkg::PAL_CH_W,
  parameter int OUT_W  = pal16_pkg::PAL_OUT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  pix_idx,
  input  logic              pix_active,
  input  logic [DATA_W-1:0] lk_data,
  input  logic              lk_written,
  output logic [OUT_W-1:0]  red,
  output logic [OUT_W-1:0]  green,
  output logic [OUT_W-1:0]  blue
);
  import pal16_pkg::*;

  logic [OUT_W-1:0] red_d, green_d, blue_d;

  always_comb begin
    if (!pix_active) begin
      red_d = '0; green_d = '0; blue_d = '0;
    end else if (!lk_written) begin
      red_d   = ramp_level(pix_idx);
      green_d = ramp_level(pix_idx);
      blue_d  = ramp_level(pix_idx);
    end else begin
      red_d   = widen_code(lk_data[CH_W-1:0]);
      green_d = widen_code(lk_data[2*CH_W-1:CH_W]);
      blue_d  = widen_code(lk_data[3*CH_W-1:2*CH_W]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      red <= '0; green <= '0; blue <= '0;
    end else begin
      red <= red_d; green <= green_d; blue <= blue_d;
    end
  end

  assert_blank_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_active |=> (red == '0) && (green == '0) && (blue == '0));
  assert_ramp_white_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_active && !lk_written && pix_idx == '0) |=> (red == '1) && (blue == '1));
endmodule

// File: rtl/pal16_lut.sv
module pal16_lut #(
  parameter int IDX_W   = pal16_pkg::PAL_IDX_W,
  parameter int DATA_W  = pal16_pkg::PAL_DATA_W,
  parameter int CH_W    = pal16_pkg::PAL_CH_W,
  parameter int OUT_W   = pal16_pkg::PAL_OUT_W,
  parameter int IDX_LSB = pal16_pkg::PAL_IDX_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [DATA_W-1:0] ctl_byte,
  input  logic              pal_wr,
  input  logic [DATA_W-1:0] pal_wdata,
  output logic [DATA_W-1:0] pal_rdata,
  input  logic [IDX_W-1:0]  pix_idx,
  input  logic              pix_active,
  output logic [OUT_W-1:0]  red,
  output logic [OUT_W-1:0]  green,
  output logic [OUT_W-1:0]  blue
);
  logic [IDX_W-1:0]  cur_idx;
  logic [DATA_W-1:0] lookup_word;
  logic              lookup_written;
  wire               store_fire = pal_wr;

  pal16_index_latch #(.DATA_W(DATA_W), .IDX_W(IDX_W), .IDX_LSB(IDX_LSB)) u_idx (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_byte(ctl_byte), .idx_q(cur_idx));

  pal16_store #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(store_fire), .wr_idx(cur_idx), .wr_data(pal_wdata),
    .rd_data(pal_rdata), .lk_idx(pix_idx), .lk_data(lookup_word), .lk_written(lookup_written));

  pal16_lookup #(.IDX_W(IDX_W), .DATA_W(DATA_W), .CH_W(CH_W), .OUT_W(OUT_W)) u_lookup (
    .clk(clk), .rst_n(rst_n), .pix_idx(pix_idx), .pix_active(pix_active),
    .lk_data(lookup_word), .lk_written(lookup_written),
    .red(red), .green(green), .blue(blue));

  assert_store_readback_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (store_fire && !ctl_wr) |=> pal_rdata == $past(pal_wdata));
  assert_store_old_index_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (store_fire && ctl_wr && (ctl_byte[IDX_LSB+IDX_W-1:IDX_LSB] == cur_idx)) |=> pal_rdata == $past(pal_wdata));
endmodule

// File: tb/pal16_lut_test.sv
module pal16_lut_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_wr = 1'b0, pal_wr = 1'b0, pix_active = 1'b0;
  logic [7:0] ctl_byte = '0, pal_wdata = '0;
  logic [3:0] pix_idx = '0;
  logic [7:0] pal_rdata, red, green, blue;

  always #10 clk = ~clk;

  pal16_lut uut (.clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_byte(ctl_byte),
    .pal_wr(pal_wr), .pal_wdata(pal_wdata), .pal_rdata(pal_rdata), .pix_idx(pix_idx),
    .pix_active(pix_active), .red(red), .green(green), .blue(blue));

  int checks = 0, errors = 0;
  bit done = 0;
  string tag = "R1";

  // behavioural model
  int m_mem [16];
  bit m_wr  [16];
  int m_idx;
  int e_r, e_g, e_b;

  function automatic int lvl(int code); return code * 85; endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) begin m_mem[i] = 0; m_wr[i] = 0; end
      m_idx = 0; e_r = 0; e_g = 0; e_b = 0;
    end else begin
      if (!pix_active) begin e_r = 0; e_g = 0; e_b = 0; end
      else if (!m_wr[pix_idx]) begin
        e_r = (pix_idx == 0) ? 255 : int'(pix_idx); e_g = e_r; e_b = e_r;
      end else begin
        e_r = lvl(m_mem[pix_idx] % 4);
        e_g = lvl((m_mem[pix_idx] / 4) % 4);
        e_b = lvl((m_mem[pix_idx] / 16) % 4);
      end
      if (pal_wr) begin m_mem[m_idx] = int'(pal_wdata); m_wr[m_idx] = 1; end
      if (ctl_wr) m_idx = (int'(ctl_byte) / 4) % 16;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("R3", "readback", int'(pal_rdata), m_mem[m_idx]);
    chk(tag, "red",   int'(red),   e_r);
    chk(tag, "green", int'(green), e_g);
    chk(tag, "blue",  int'(blue),  e_b);
  end

  task automatic tick; @(negedge clk); endtask
  task automatic idle;
    ctl_wr = 0; pal_wr = 0; pix_active = 0;
  endtask
  task automatic set_idx(int i, int junk);
    ctl_wr = 1; ctl_byte = 8'((i << 2) | (junk & 8'hC3)); tick; ctl_wr = 0;
  endtask
  task automatic store(int i, int d);
    set_idx(i, 8'hC3); pal_wr = 1; pal_wdata = 8'(d); tick; pal_wr = 0;
  endtask
  task automatic scan;
    for (int i = 0; i < 16; i++) begin pix_active = 1; pix_idx = 4'(i); tick; end
    pix_active = 0; tick;
  endtask

  task automatic summary;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary;
  end

  initial begin
    repeat (3) tick;
    rst_n = 1; tick;
    // R1: reset state at the ports
    tag = "R1";
    chk("R1", "red after reset", int'(red), 0);
    chk("R1", "readback idx0 after reset", int'(pal_rdata), 0);
    for (int i = 0; i < 16; i++) begin set_idx(i, 0); tick; end
    // R6: ramp for unwritten entries, R7 pipeline
    tag = "R6"; scan;
    // R2: junk control bits ignored
    tag = "R2";
    set_idx(5, 8'hFF); tick;
    chk("R2", "readback after junk ctl", int'(pal_rdata), 0);
    // R3: full byte stored, readback immediate
    tag = "R3";
    store(5, 8'hE7); chk("R3", "byte incl. bits 7:6", int'(pal_rdata), 8'hE7);
    // same-cycle ctl + pal writes: old index
    set_idx(9, 0);
    ctl_wr = 1; ctl_byte = 8'(3 << 2); pal_wr = 1; pal_wdata = 8'h2D; tick; idle;
    chk("R3", "idx3 untouched", int'(pal_rdata), 0);
    set_idx(9, 0); chk("R3", "old index 9 got data", int'(pal_rdata), 8'h2D);
    // R4/R5: channel codes and mapping
    tag = "R4";
    store(1, 8'h01); store(2, 8'h04); store(4, 8'h10); store(6, 8'hC0);
    tag = "R5";
    store(7, 8'h1B); store(8, 8'h3F); store(10, 8'h2A);
    tag = "R4"; scan;
    // R8: lookup in the write cycle sees old contents
    tag = "R8";
    set_idx(12, 0);
    pal_wr = 1; pal_wdata = 8'h15; pix_active = 1; pix_idx = 12; tick;
    pal_wr = 0; tick; pix_active = 0; tick;
    // R7: blanking interleaved
    tag = "R7";
    for (int i = 0; i < 32; i++) begin
      pix_active = i[0]; pix_idx = 4'(i); tick;
    end
    idle;
    // random overlap phase
    tag = "R8";
    for (int n = 0; n < 3000; n++) begin
      ctl_wr = ($urandom % 4) == 0; ctl_byte = 8'($urandom);
      pal_wr = ($urandom % 3) == 0; pal_wdata = 8'($urandom);
      pix_active = ($urandom % 5) != 0; pix_idx = 4'($urandom);
      tick;
    end
    idle; tick;
    // reset again clears written state
    tag = "R1";
    rst_n = 0; tick; tick; rst_n = 1; tick;
    tag = "R6"; scan;
    summary;
  end
endmodule